// File: doc/BRIEF.md
# Fraction Arithmetic Helper Unit

This block is a multicycle functional unit for exact rational arithmetic on packed fraction words. Each 32-bit word carries an unsigned 16-bit numerator in its upper half and an unsigned 16-bit denominator in its lower half. The unit provides four helper operations that a datapath sequences around its ordinary integer ALU. They are the least common multiple of two denominators, the pair of factors that bring two denominators to that common multiple, the reciprocal, and reduction to lowest terms.

A request is made by raising `start` with an operation code and two operand words while the unit is idle. The operands are captured on that cycle. Inside the unit a greatest common divisor is found by repeated subtraction, and a shared restoring shift-subtract divider then produces the quotients. When the result is ready, `done` pulses for one cycle, and the result and its flags hold until the next request completes. A separate 32-bit destination register sits beside the unit. It can latch either half of a bus word into either of its own halves.

Top module: `frac_unit`

## Requirements
- R1: With op code 2 (invert), a valid operand n/d gives result {d, n}, with the denominator in bits 31:16 and the numerator in bits 15:0. Err and ovf are 0.
- R2: With op code 0 (common multiple), the result holds lcm(d1, d2) of the two operand denominators in bits 15:0 and zero in bits 31:16. When the true value exceeds 16 bits, ovf is 1 and bits 15:0 hold its low 16 bits. Otherwise ovf is 0.
- R3: With op code 1 (scale factors), the result has numerator lcm/d1 = d2/g and denominator lcm/d2 = d1/g, where g = gcd(d1, d2).
- R4: With op code 3 (reduce), the result is {n/g, d/g} with g = gcd(n, d). A zero numerator with a nonzero denominator gives 0/1, which is the word 0x00000001.
- R5: A zero denominator in any operand the operation uses sets err to 1 and gives result 0 and ovf 0. So does a zero numerator given to invert. The second operand is used only by op codes 0 and 1.
- R6: Done is high for exactly one cycle per accepted request, and busy is low in that cycle. Busy is high from the cycle after acceptance until the result appears. Result, err and ovf change only together with done.
- R7: A start raised while busy is 1 is ignored: it yields no extra done and does not change the result. Operand and op inputs that change after acceptance have no effect on the pending result.
- R8: When dst_en is 1, the destination register updates on the next clock edge according to dst_mode. Mode 0 copies bus bits 31:16 into register bits 15:0. Mode 1 copies bus bits 15:0 into register bits 15:0. Mode 2 copies bus bits 15:0 into register bits 31:16. Mode 3 copies bus bits 31:16 into register bits 31:16. The other register half is kept in every mode. When dst_en is 0, the register holds its value.
- R9: After reset, result, done, busy, err, ovf and dst_q are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| op | input | 2 | 0 common multiple, 1 scale factors, 2 invert, 3 reduce |
| opa | input | 32 | First fraction operand {numerator, denominator} |
| opb | input | 32 | Second fraction operand (denominator used by op 0 and 1) |
| result | output | 32 | Result word, held between requests |
| done | output | 1 | One-cycle pulse when result is valid |
| busy | output | 1 | High while a request is in progress |
| err | output | 1 | Invalid operand flag for the last result |
| ovf | output | 1 | Common multiple exceeded 16 bits |
| dst_en | input | 1 | Destination register write enable |
| dst_mode | input | 2 | Half-word latch mode |
| dst_bus | input | 32 | Bus word feeding the destination register |
| dst_q | output | 32 | Destination register contents |

## Verification
Several properties are checked on every cycle:
- Done is a single-cycle pulse and only appears while busy is low.
- The result never moves without done.
- An error result is always zero.
- An overflowed or plain common multiple has a clear upper half.
- Captured operands stay frozen while busy.
- Every divider result satisfies quotient times divisor plus remainder equals the dividend.
- The GCD loop never holds a zero.
- The destination register keeps the half that its latch mode does not address.

The actual arithmetic values, the 0/1 reduction, the error cases and the dropping of a start issued mid-request are visible only in the bench's scenarios, which compare against hand-derived results.

// File: rtl/frac_pkg.sv
package frac_pkg;
  localparam int HALF = 16;
  localparam int WORD = 2 * HALF;

  typedef logic [HALF-1:0] half_t;
  typedef logic [WORD-1:0] word_t;

  typedef enum logic [1:0] {
    OP_LCM  = 2'd0,
    OP_LCMS = 2'd1,
    OP_INV  = 2'd2,
    OP_RED  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    LM_HI2LO = 2'd0,
    LM_LO2LO = 2'd1,
    LM_LO2HI = 2'd2,
    LM_HI2HI = 2'd3
  } lmode_e;

  // Merge one half of a bus word into one half of a register word.
  function automatic word_t latch_merge(word_t q, word_t bus, lmode_e m);
    word_t r;
    r = q;
    case (m)
      LM_HI2LO: r[HALF-1:0]    = bus[WORD-1:HALF];
      LM_LO2LO: r[HALF-1:0]    = bus[HALF-1:0];
      LM_LO2HI: r[WORD-1:HALF] = bus[HALF-1:0];
      default:  r[WORD-1:HALF] = bus[WORD-1:HALF];
    endcase
    return r;
  endfunction

  // One restoring division step: returns {remainder, quotient/dividend shift}.
  function automatic logic [2*HALF:0] div_step(logic [HALF:0] rem, half_t quo, half_t dv);
    logic [HALF:0] sh;
    logic [HALF:0] rs;
    logic          fit;
    sh  = {rem[HALF-1:0], quo[HALF-1]};
    fit = (sh >= {1'b0, dv});
    rs  = fit ? (sh - {1'b0, dv}) : sh;
    return {rs, quo[HALF-2:0], fit};
  endfunction

  // One subtractive Euclid step: larger value loses the smaller one.
  function automatic logic [WORD-1:0] gcd_step(half_t x, half_t y);
    if (x > y) return {x - y, y};
    else       return {x, y - x};
  endfunction
endpackage

// File: rtl/frac_gcd.sv
module frac_gcd
  import frac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  half_t x,
  input  half_t y,
  output logic  done,
  output half_t g
);
  half_t ga, gb;
  logic  run;
  logic  settled;

  assign settled = (ga == gb);
  assign g       = ga;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ga   <= '0;
      gb   <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        ga  <= x;
        gb  <= y;
        run <= 1'b1;
      end else if (run) begin
        if (settled) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          {ga, gb} <= gcd_step(ga, gb);
        end
      end
    end
  end

  // R4: the Euclid loop only ever runs on two nonzero values
  p_gcd_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ga != '0) && (gb != '0));
endmodule

// File: rtl/frac_div.sv
module frac_div
  import frac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  half_t num,
  input  half_t den,
  output logic  done,
  output half_t quo
);
  localparam int CW = $clog2(HALF + 1);

  logic [HALF:0]   rem;
  half_t           dv;
  half_t           num_keep;
  logic [CW-1:0]   cnt;
  logic            run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem      <= '0;
      quo      <= '0;
      dv       <= '0;
      num_keep <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem      <= '0;
        quo      <= num;
        dv       <= den;
        num_keep <= num;
        cnt      <= CW'(HALF);
        run      <= 1'b1;
      end else if (run) begin
        {rem, quo} <= div_step(rem, quo, dv);
        cnt        <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4: every finished division is exact in the Euclidean sense
  p_div_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((33'(quo) * 33'(dv) + 33'(rem)) == 33'(num_keep)) && (rem < {1'b0, dv}));
endmodule

// File: rtl/frac_dreg.sv
module frac_dreg
  import frac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  word_t      bus,
  output word_t      q
);
  lmode_e m;
  logic   hits_hi;

  assign m       = lmode_e'(mode);
  assign hits_hi = (m == LM_LO2HI) || (m == LM_HI2HI);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (en) q <= latch_merge(q, bus, m);
  end

  // R8: the half not addressed by the mode keeps its value
  p_keep_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && hits_hi |=> q[HALF-1:0] == $past(q[HALF-1:0]));
  p_keep_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && !hits_hi |=> q[WORD-1:HALF] == $past(q[WORD-1:HALF]));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/frac_unit.sv
module frac_unit
  import frac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  output logic [31:0] result,
  output logic        done,
  output logic        busy,
  output logic        err,
  output logic        ovf,
  input  logic        dst_en,
  input  logic [1:0]  dst_mode,
  input  logic [31:0] dst_bus,
  output logic [31:0] dst_q
);
  typedef enum logic [2:0] {S_IDLE, S_GCD, S_DIV1, S_DIV2, S_FIN} st_e;

  st_e   st;
  op_e   op_in, op_q;
  half_t a_num, a_den, b_den;
  half_t x_q, y_q, g_q, q1_q, q2_q, div_num;
  logic  bad_q, gcd_go, div_go;
  logic  accept, uses_b, bad_in, short_in;
  logic  gcd_done, div_done;
  half_t gcd_g, div_quo;
  word_t lcm_w, fin_res;
  logic  fin_ovf;

  assign op_in  = op_e'(op);
  assign a_num  = opa[WORD-1:HALF];
  assign a_den  = opa[HALF-1:0];
  assign b_den  = opb[HALF-1:0];
  assign accept = start && (st == S_IDLE);
  assign busy   = (st != S_IDLE);
  assign uses_b = (op_in == OP_LCM) || (op_in == OP_LCMS);
  assign bad_in = (a_den == '0) || (uses_b && (b_den == '0)) ||
                  ((op_in == OP_INV) && (a_num == '0));
  assign short_in = bad_in || (op_in == OP_INV) || ((op_in == OP_RED) && (a_num == '0));

  frac_gcd u_gcd (
    .clk(clk), .rst_n(rst_n), .go(gcd_go), .x(x_q), .y(y_q),
    .done(gcd_done), .g(gcd_g)
  );

  frac_div u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(g_q),
    .done(div_done), .quo(div_quo)
  );

  frac_dreg u_dreg (
    .clk(clk), .rst_n(rst_n), .en(dst_en), .mode(dst_mode),
    .bus(dst_bus), .q(dst_q)
  );

  // x_q/y_q: for common-multiple ops these are d2/d1, else numerator/denominator
  assign lcm_w = word_t'(q1_q) * word_t'(y_q);

  always_comb begin
    fin_res = '0;
    fin_ovf = 1'b0;
    if (!bad_q) begin
      case (op_q)
        OP_LCM: begin
          fin_res = {{HALF{1'b0}}, lcm_w[HALF-1:0]};
          fin_ovf = |lcm_w[WORD-1:HALF];
        end
        OP_LCMS: fin_res = {q1_q, q2_q};
        OP_INV:  fin_res = {y_q, x_q};
        default: fin_res = (x_q == '0) ? word_t'(1) : {q1_q, q2_q};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_LCM;
      x_q     <= '0;
      y_q     <= '0;
      g_q     <= '0;
      q1_q    <= '0;
      q2_q    <= '0;
      div_num <= '0;
      bad_q   <= 1'b0;
      gcd_go  <= 1'b0;
      div_go  <= 1'b0;
      result  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      gcd_go <= 1'b0;
      div_go <= 1'b0;
      done   <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_q  <= op_in;
          x_q   <= uses_b ? b_den : a_num;
          y_q   <= a_den;
          bad_q <= bad_in;
          if (short_in) st <= S_FIN;
          else begin
            st     <= S_GCD;
            gcd_go <= 1'b1;
          end
        end
        S_GCD: if (gcd_done) begin
          g_q     <= gcd_g;
          div_num <= x_q;
          div_go  <= 1'b1;
          st      <= S_DIV1;
        end
        S_DIV1: if (div_done) begin
          q1_q    <= div_quo;
          div_num <= y_q;
          div_go  <= 1'b1;
          st      <= S_DIV2;
        end
        S_DIV2: if (div_done) begin
          q2_q <= div_quo;
          st   <= S_FIN;
        end
        default: begin
          result <= fin_res;
          err    <= bad_q;
          ovf    <= fin_ovf;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  // R6: done is a lone pulse, seen only once the unit is idle again
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result) && $stable(err) && $stable(ovf));
  // R5: an error always reports a zero word
  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (result == '0) && !ovf);
  // R2: overflow only on a result whose upper half is clear
  p_ovf_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result[WORD-1:HALF] == '0));
  // R7: captured request cannot move while a request runs
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_q) && $stable(y_q) && $stable(op_q) && $stable(bad_q));
endmodule

// File: tb/tb_frac_unit.sv
module tb_frac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        done, busy, err, ovf;
  logic        dst_en = 1'b0;
  logic [1:0]  dst_mode = 2'd0;
  logic [31:0] dst_bus = '0;
  logic [31:0] dst_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  frac_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .result(result), .done(done), .busy(busy), .err(err), .ovf(ovf),
    .dst_en(dst_en), .dst_mode(dst_mode), .dst_bus(dst_bus), .dst_q(dst_q)
  );

  // {op, a, b, expected result, err, ovf}
  localparam int NV = 16;
  localparam logic [99:0] VEC [NV] = '{
    {2'd0, 32'h0003_0004, 32'h0005_0006, 32'h0000_000C, 1'b0, 1'b0},
    {2'd1, 32'h0003_0004, 32'h0005_0006, 32'h0003_0002, 1'b0, 1'b0},
    {2'd2, 32'h0003_0007, 32'h0000_0000, 32'h0007_0003, 1'b0, 1'b0},
    {2'd3, 32'h0006_0008, 32'h0000_0000, 32'h0003_0004, 1'b0, 1'b0},
    {2'd3, 32'h0000_0009, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0},
    {2'd0, 32'h0001_0100, 32'h0001_0101, 32'h0000_0100, 1'b0, 1'b1},
    {2'd0, 32'h0001_0004, 32'h0001_0000, 32'h0000_0000, 1'b1, 1'b0},
    {2'd2, 32'h0000_0005, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    {2'd3, 32'h0005_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    {2'd1, 32'h0001_000A, 32'h0001_0004, 32'h0002_0005, 1'b0, 1'b0},
    {2'd3, 32'h0015_0023, 32'h0000_0000, 32'h0003_0005, 1'b0, 1'b0},
    {2'd0, 32'h0001_0007, 32'h0002_0007, 32'h0000_0007, 1'b0, 1'b0},
    {2'd0, 32'h0001_FFFF, 32'h0009_FFFF, 32'h0000_FFFF, 1'b0, 1'b0},
    {2'd3, 32'h0007_000B, 32'h0000_0000, 32'h0007_000B, 1'b0, 1'b0},
    {2'd2, 32'h0005_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    {2'd1, 32'h0002_0003, 32'h0004_0000, 32'h0000_0000, 1'b1, 1'b0}
  };

  function automatic string tag(logic [1:0] o, logic e);
    if (e) return "R5";
    case (o)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R1";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Global watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic issue(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {result[31:1], done | result[0]}, 32'h0);
    check("R9", {28'h0, busy, err, ovf, done}, 32'h0);
    check("R9", dst_q, 32'h0);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      v = VEC[i];
      issue(v[99:98], v[97:66], v[65:34]);
      opa = 32'hDEAD_BEEF; opb = 32'h0; // R7: post-accept change has no effect
      wait_done();
      check(tag(v[99:98], v[1]), result, v[33:2]);
      check(tag(v[99:98], v[1]), {30'h0, err, ovf}, {30'h0, v[1], v[0]});
      check("R6", {31'h0, busy}, 32'h0);
      @(negedge clk);
      check("R6", {31'h0, done}, 32'h0);
    end

    // R7: start while busy is dropped
    issue(2'd0, 32'h0001_0100, 32'h0001_0101);
    check("R6", {31'h0, busy}, 32'h1);
    @(negedge clk);
    start = 1'b1; op = 2'd2; opa = 32'h0003_0007;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R7", result, 32'h0000_0100);
    check("R7", {31'h0, ovf}, 32'h1);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R7", extra, 0);
      check("R7", result, 32'h0000_0100);
    end

    // R8 destination register modes
    @(negedge clk); dst_en = 1'b1; dst_mode = 2'd3; dst_bus = 32'hAAAA_BBBB;
    @(negedge clk); check("R8", dst_q, 32'hAAAA_0000);
    dst_mode = 2'd0; dst_bus = 32'h1234_5678;
    @(negedge clk); check("R8", dst_q, 32'hAAAA_1234);
    dst_mode = 2'd2; dst_bus = 32'h9999_CDEF;
    @(negedge clk); check("R8", dst_q, 32'hCDEF_1234);
    dst_mode = 2'd1; dst_bus = 32'h0000_4321;
    @(negedge clk); check("R8", dst_q, 32'hCDEF_4321);
    dst_en = 1'b0; dst_mode = 2'd3; dst_bus = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk); check("R8", dst_q, 32'hCDEF_4321);

    finish_run();
  end
endmodule